// File: doc/BRIEF.md
# Boot ROM Access Limit Guard

This block sits between a register-bus requester and an on-chip boot ROM and blocks any ROM read at or above a programmable limit. The limit marks the first address that may not be read. It can be lowered by a CSR write but never raised, so boot code can give up access to ROM regions it no longer needs.

The limit gets its starting value when reset is released, in one of two ways, picked by the `trusted_i` strap. In trusted mode it takes the full ROM size. Otherwise a short load sequence fetches a limit word stored twelve words below the top of the ROM. ROM reads made before the limit is settled are answered busy, without data.

The controller is a three-state machine. The states are:
- `S_FETCH`: entered from reset.
- `S_CAPTURE`: holds for one cycle while the stored limit word is read.
- `S_RUN`: normal service.

The transitions are:
- `S_FETCH` to `S_RUN` when `trusted_i` is high.
- `S_FETCH` to `S_CAPTURE` when `trusted_i` is low. This transition issues the ROM fetch of the limit word.
- `S_CAPTURE` to `S_RUN`. This transition loads the low 17 bits of the fetched word into the limit.
- `S_RUN` stays in `S_RUN`.

The ROM model is a synchronous pattern store. Word `a` holds `{~a[15:0], a[15:0]}`. The limit-word address `ROM_SIZE-12` (0x3FF4 by default) instead holds `{15'h2B3C, 17'h03000}`.

Top module: `rom_limit_guard`

## Requirements
- R1: With `trusted_i`=1, once out of reset the limit reads 0x4000 on `csr_rdata_o`.
- R2: With `trusted_i`=0, once the load sequence ends the limit equals bits [16:0] of the ROM word at address 0x3FF4 (0x3000 by default). The upper 15 bits of that word are discarded.
- R3: A read request accepted in `S_RUN` is answered one cycle later with `rd_valid_o`=1 and `rd_data_o` equal to the ROM word at that address.
- R4: A read at an address greater than or equal to the limit is answered with `rd_valid_o`=1, `rd_fault_o`=1 and `rd_data_o`=0. A read at limit-1 does not fault.
- R5: A CSR write whose value is greater than the current limit leaves the limit unchanged.
- R6: A CSR write whose value is less than or equal to the current limit becomes the new limit on the next cycle.
- R7: `csr_rdata_o` holds the limit in bits [16:0], and bits [31:17] read as zero.
- R8: A read request made before `S_RUN` is answered one cycle later with `rd_busy_o`=1 and `rd_valid_o`=0.
- R9: When a CSR write and a ROM read occur in the same cycle, both take effect, and the read is judged against the limit held before the write.
- R10: A cycle with no request is followed by a cycle with `rd_valid_o`, `rd_busy_o` and `rd_fault_o` all low and `rd_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trusted_i | input | 1 | Boot-mode strap: 1 = trusted (full size), 0 = load the limit from ROM |
| rd_req_i | input | 1 | ROM read request |
| rd_addr_i | input | 17 | ROM read address |
| rd_valid_o | output | 1 | Read response carries a result |
| rd_data_o | output | 32 | Read data; zero on a fault or when there is no response |
| rd_fault_o | output | 1 | Read address was at or above the limit |
| rd_busy_o | output | 1 | Read was refused because the limit was not settled |
| csr_wr_i | input | 1 | Limit write strobe |
| csr_wdata_i | input | 17 | Proposed new limit |
| csr_rdata_o | output | 32 | Current limit, zero-extended |

## Verification
Two functions can coincide in one cycle: a shrinking CSR write and a ROM read.

The bench provokes this by raising `csr_wr_i` and `rd_req_i` on the same edge. The write lowers the limit to just below the read address, while the limit in force before the write is above it. The read must come back without a fault and with real data. A second read at the same address after the write must fault, and the CSR readback must show the lowered value.

A read issued during the untrusted load sequence is also checked. It must be answered busy rather than read against a limit that is not yet settled.

// File: rtl/romlg_pkg.sv
package romlg_pkg;

    typedef enum logic [1:0] {
        S_FETCH   = 2'd0,
        S_CAPTURE = 2'd1,
        S_RUN     = 2'd2
    } guard_state_t;

endpackage

// File: rtl/romlg_rom.sv
// Synchronous boot ROM model whose contents are computed from the address.
module romlg_rom #(
    parameter int              ADDR_W    = 17,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] WORD_LOC  = 17'h03FF4,
    parameter logic [DATA_W-1:0] LOC_WORD  = 32'h5678_3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] q_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] word_d;

    always_comb begin
        if (addr_i == WORD_LOC) begin
            word_d = LOC_WORD;
        end else begin
            word_d = '0;
            word_d[HALF_W-1:0]      = HALF_W'(addr_i);
            word_d[DATA_W-1:HALF_W] = ~HALF_W'(addr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (en_i) begin
            q_o <= word_d;
        end
    end
endmodule

// File: rtl/romlg_limit_reg.sv
// Shrink-only limit register with post-reset load.
module romlg_limit_reg #(
    parameter int                ADDR_W    = 17,
    parameter logic [ADDR_W-1:0] FULL_SIZE = 17'h04000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] limit_o
);
    logic accept_wr;

    always_comb begin
        accept_wr = wr_i && run_i && (wdata_i <= limit_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_o <= FULL_SIZE;
        end else if (load_i) begin
            limit_o <= load_val_i;
        end else if (accept_wr) begin
            limit_o <= wdata_i;
        end
    end

    // R5: once in service the limit never grows
    a_r5_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_i) && run_i) |-> (limit_o <= $past(limit_o)));

    // R6: an accepted write shows up one cycle later
    a_r6_shrink_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && run_i && !load_i && (wdata_i <= limit_o)) |=> (limit_o == $past(wdata_i)));
endmodule

// File: rtl/romlg_ctrl.sv
// Load sequencer and read-response stage.
module romlg_ctrl
    import romlg_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter logic [ADDR_W-1:0] WORD_LOC = 17'h03FF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trusted_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [ADDR_W-1:0] limit_i,
    output logic              rom_en_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              load_o,
    output logic              run_o,
    output logic              resp_valid_o,
    output logic              resp_fault_o,
    output logic              resp_busy_o
);
    guard_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d    = state_q;
        rom_en_o   = 1'b0;
        rom_addr_o = WORD_LOC;
        load_o     = 1'b0;
        run_o      = 1'b0;
        unique case (state_q)
            S_FETCH: begin
                if (trusted_i) begin
                    state_d = S_RUN;
                end else begin
                    rom_en_o = 1'b1;
                    state_d  = S_CAPTURE;
                end
            end
            S_CAPTURE: begin
                load_o  = 1'b1;
                state_d = S_RUN;
            end
            S_RUN: begin
                run_o      = 1'b1;
                rom_en_o   = rd_req_i;
                rom_addr_o = rd_addr_i;
            end
            default: begin
                state_d = S_FETCH;
            end
        endcase
    end

    // response stage: judged against the limit held before any same-cycle write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            resp_fault_o <= 1'b0;
            resp_busy_o  <= 1'b0;
        end else begin
            resp_valid_o <= rd_req_i && run_o;
            resp_fault_o <= rd_req_i && run_o && (rd_addr_i >= limit_i);
            resp_busy_o  <= rd_req_i && !run_o;
        end
    end

    // R8: a request before service is answered busy
    a_r8_early_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && (state_q != S_RUN)) |=> (resp_busy_o && !resp_valid_o));

    // R3: a response never appears without a request one cycle earlier
    a_r3_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> $past(rd_req_i));

    // R10: valid and busy are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_valid_o, resp_busy_o}));
endmodule

// File: rtl/rom_limit_guard.sv
module rom_limit_guard #(
    parameter int                ADDR_W    = 17,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] ROM_SIZE  = 17'h04000,
    parameter logic [ADDR_W-1:0] STORED_LIMIT = 17'h03000,
    parameter logic [DATA_W-ADDR_W-1:0] STORED_TAG = 15'h2B3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trusted_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_fault_o,
    output logic              rd_busy_o,
    input  logic              csr_wr_i,
    input  logic [ADDR_W-1:0] csr_wdata_i,
    output logic [DATA_W-1:0] csr_rdata_o
);
    localparam logic [ADDR_W-1:0] WORD_LOC = ROM_SIZE - ADDR_W'(12);
    localparam logic [DATA_W-1:0] LOC_WORD = {STORED_TAG, STORED_LIMIT};

    logic              rom_en;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_q;
    logic              load;
    logic              run;
    logic [ADDR_W-1:0] limit;

    romlg_ctrl #(.ADDR_W(ADDR_W), .WORD_LOC(WORD_LOC)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .trusted_i    (trusted_i),
        .rd_req_i     (rd_req_i),
        .rd_addr_i    (rd_addr_i),
        .limit_i      (limit),
        .rom_en_o     (rom_en),
        .rom_addr_o   (rom_addr),
        .load_o       (load),
        .run_o        (run),
        .resp_valid_o (rd_valid_o),
        .resp_fault_o (rd_fault_o),
        .resp_busy_o  (rd_busy_o)
    );

    romlg_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_LOC(WORD_LOC), .LOC_WORD(LOC_WORD)) rom_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (rom_en),
        .addr_i (rom_addr),
        .q_o    (rom_q)
    );

    romlg_limit_reg #(.ADDR_W(ADDR_W), .FULL_SIZE(ROM_SIZE)) limit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .load_i     (load),
        .load_val_i (rom_q[ADDR_W-1:0]),
        .wr_i       (csr_wr_i),
        .wdata_i    (csr_wdata_i),
        .limit_o    (limit)
    );

    always_comb begin
        rd_data_o   = (rd_valid_o && !rd_fault_o) ? rom_q : '0;
        csr_rdata_o = DATA_W'(limit);
    end

    // R4: a faulting response carries no data
    a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault_o |-> (rd_valid_o && (rd_data_o == '0)));

    // R7: upper readback bits are zero
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata_o[DATA_W-1:ADDR_W] == '0);
endmodule

// File: tb/rom_limit_guard_tb_top.sv
`timescale 1ns/1ps
module rom_limit_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trusted_i = 1'b1;
    logic        rd_req_i = 1'b0;
    logic [16:0] rd_addr_i = '0;
    logic        rd_valid_o, rd_fault_o, rd_busy_o;
    logic [31:0] rd_data_o, csr_rdata_o;
    logic        csr_wr_i = 1'b0;
    logic [16:0] csr_wdata_i = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    rom_limit_guard dut_i (
        .clk(clk), .rst_n(rst_n), .trusted_i(trusted_i),
        .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .rd_fault_o(rd_fault_o), .rd_busy_o(rd_busy_o),
        .csr_wr_i(csr_wr_i), .csr_wdata_i(csr_wdata_i),
        .csr_rdata_o(csr_rdata_o)
    );

    function automatic logic [31:0] rom_word(input logic [16:0] a);
        if (a == 17'h03FF4) return 32'h5678_3000;
        return {~a[15:0], a[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic trusted);
        @(negedge clk);
        rst_n = 1'b0;
        trusted_i = trusted;
        rd_req_i = 1'b0;
        csr_wr_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one read in service, judged after its response cycle
    task automatic read_chk(input string req, input logic [16:0] a, input logic fault);
        rd_req_i = 1'b1; rd_addr_i = a;
        @(negedge clk);
        rd_req_i = 1'b0;
        check(req, {29'd0, rd_valid_o, rd_fault_o, rd_busy_o}, {29'd0, 1'b1, fault, 1'b0});
        check(req, rd_data_o, fault ? 32'h0 : rom_word(a));
    endtask

    task automatic write_chk(input string req, input logic [16:0] v, input logic [16:0] exp);
        csr_wr_i = 1'b1; csr_wdata_i = v;
        @(negedge clk);
        csr_wr_i = 1'b0;
        check(req, csr_rdata_o, {15'd0, exp});
    endtask

    task automatic t_trusted_boot;
        do_reset(1'b1);
        // R8: request in the first cycle after release is refused
        rd_req_i = 1'b1; rd_addr_i = 17'h5;
        @(negedge clk);
        rd_req_i = 1'b0;
        check("R8", {30'd0, rd_valid_o, rd_busy_o}, 32'h1);
        check("R1", csr_rdata_o, 32'h0000_4000);
        check("R7", {csr_rdata_o[31:17], 17'd0}, 32'h0);
    endtask

    task automatic t_reads;
        read_chk("R3", 17'h00010, 1'b0);
        read_chk("R3", 17'h03FF4, 1'b0);
        read_chk("R4", 17'h03FFF, 1'b0);
        read_chk("R4", 17'h04000, 1'b1);
        read_chk("R4", 17'h1FFFF, 1'b1);
        @(negedge clk);
        check("R10", {rd_valid_o, rd_busy_o, rd_fault_o, 29'd0}, 32'h0);
        check("R10", rd_data_o, 32'h0);
    endtask

    task automatic t_writes;
        write_chk("R5", 17'h05000, 17'h04000);
        write_chk("R5", 17'h1FFFF, 17'h04000);
        write_chk("R6", 17'h04000, 17'h04000);
        write_chk("R6", 17'h00100, 17'h00100);
        read_chk("R6", 17'h000FF, 1'b0);
        read_chk("R6", 17'h00100, 1'b1);
    endtask

    task automatic t_same_cycle;
        csr_wr_i = 1'b1; csr_wdata_i = 17'h00080;
        rd_req_i = 1'b1; rd_addr_i = 17'h000C0;
        @(negedge clk);
        csr_wr_i = 1'b0; rd_req_i = 1'b0;
        check("R9", {31'd0, rd_fault_o}, 32'h0);
        check("R9", rd_data_o, rom_word(17'h000C0));
        check("R9", csr_rdata_o, 32'h0000_0080);
        read_chk("R9", 17'h000C0, 1'b1);
    endtask

    task automatic t_untrusted_boot;
        do_reset(1'b0);
        rd_req_i = 1'b1; rd_addr_i = 17'h00020;
        @(negedge clk);
        check("R8", {30'd0, rd_valid_o, rd_busy_o}, 32'h1);
        @(negedge clk);
        check("R8", {30'd0, rd_valid_o, rd_busy_o}, 32'h1);
        rd_req_i = 1'b0;
        check("R2", csr_rdata_o, 32'h0000_3000);
        @(negedge clk);
        read_chk("R2", 17'h02FFF, 1'b0);
        read_chk("R2", 17'h03000, 1'b1);
        write_chk("R5", 17'h03001, 17'h03000);
    endtask

    initial begin
        t_trusted_boot();
        t_reads();
        t_writes();
        t_same_cycle();
        t_untrusted_boot();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule